// File: doc/BRIEF.md
# Two-Line Masked Interrupt Controller

This block keeps the pending-event register and the enable-mask register of an Ethernet controller, and turns their overlap into two level-sensitive interrupt lines. The transmit, receive, MII and timer logic report events as one-cycle pulses on a 32-bit event vector. Each pulse sets the matching pending bit, and the bit then stays set until software clears it.

Software uses a simple synchronous write port and a combinational read port. A one-bit select chooses the register. On the pending register, writing a one clears that bit and writing a zero leaves it alone. On the mask register, a write is a plain store.

The two outputs split the masked events by a fixed grouping. The main line covers the sixteen MAC and DMA events in bits 31 to 16, which include frame and buffer completion on both directions, babbling, heartbeat, graceful stop, MII completion, bus error, late collision, retry limit, underrun, payload error, wakeup and timestamp availability. The timer line covers only bit 15, the timestamp-timer event. Both outputs are computed directly from the registers, so they follow every register change with no extra delay.

Top module: `irq_split_ctrl`

## Requirements
- R1: After reset, both registers read zero and both interrupt lines are low.
- R2: A one on `evt_pulse[b]`, for any b from 15 to 31, sets pending bit b at the next clock edge.
- R3: A write with `wr_sel`=0 (pending register) clears every pending bit whose data bit is one and leaves the other pending bits unchanged.
- R4: When a pulse and a clearing write hit the same pending bit in the same cycle, the pulse wins and the bit stays set.
- R5: A write with `wr_sel`=1 (mask register) stores bits 31 to 15 of `wr_data`. With `rd_sel`=1 the stored mask is read back, and with `rd_sel`=0 the pending register is read back. A mask write does not change the pending register.
- R6: Bits 14 to 0 of both registers always read zero. Writes to these bits and pulses on them have no effect.
- R7: `irq_timer` is high exactly when bit 15 is set in both the pending register and the mask register.
- R8: `irq_main` is high exactly when some bit from 31 to 16 is set in both registers. Bit 15 never affects `irq_main`.
- R9: Both lines are derived combinationally from the registers. A line therefore changes in the same cycle that the register update from a pulse, clear or mask write becomes visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous controller reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 is the pending register (write one to clear), 1 is the mask register |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 is the pending register, 1 is the mask register |
| rd_data | output | 32 | Read data for the register chosen by `rd_sel` |
| evt_pulse | input | 32 | Event pulses; bit b sets pending bit b |
| irq_main | output | 1 | Level interrupt for masked MAC/DMA events (bits 31 to 16) |
| irq_timer | output | 1 | Level interrupt for the masked timestamp-timer event (bit 15) |

## Verification
The assertions assume that `wr_en`, `wr_sel`, `wr_data` and `evt_pulse` have known values at every clock edge after reset. They also assume that a pulse is sampled only at an edge, so it has no combinational path to the lines. The stimulus meets these assumptions in two ways. It holds reset across the first edges, and it changes every input only on the falling clock edge, with inactive defaults between operations. The vectors walk each main-group bit on its own, put a clear and a pulse on the same bit in the same cycle, and write the unimplemented low bits through both the write port and the pulse vector.

// File: rtl/irq_split_pkg.sv
package irq_split_pkg;

    localparam int REG_W   = 32;
    localparam int TMR_BIT = 15;
    localparam int N_LINES = 2;

    // Bits TMR_BIT..REG_W-1 exist; everything below reads zero.
    localparam logic [REG_W-1:0] IMPL_BITS = ~((32'(1) << TMR_BIT) - 32'(1));
    localparam logic [REG_W-1:0] TMR_GRP   = 32'(1) << TMR_BIT;
    localparam logic [REG_W-1:0] MAIN_GRP  = IMPL_BITS & ~TMR_GRP;

    // Line 0 = main, line 1 = timer.
    localparam logic [N_LINES*REG_W-1:0] LINE_GROUPS = {TMR_GRP, MAIN_GRP};

    typedef enum logic {
        SEL_PEND = 1'b0,
        SEL_MASK = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int               W    = irq_split_pkg::REG_W,
    parameter logic [W-1:0]     IMPL = irq_split_pkg::IMPL_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pulse_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_o
);

    typedef struct packed {
        logic [W-1:0] pend;
    } pend_state_t;

    pend_state_t st_d, st_q;
    logic [W-1:0] nxt_d;

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (IMPL[b]) begin : g_live
            // A pulse outranks a clear on the same bit.
            assign nxt_d[b] = pulse_i[b] | (st_q.pend[b] & ~clr_i[b]);
        end else begin : g_tied
            assign nxt_d[b] = 1'b0;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.pend = nxt_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R2 / R4: every live pulse is pending after the edge, whatever the clear.
    assert_pulse_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pulse_i & IMPL) != '0) |=> ((pend_o & $past(pulse_i & IMPL)) == $past(pulse_i & IMPL)));

    // R3: cleared bits without a competing pulse drop.
    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((pend_o & $past(clr_i & ~pulse_i)) == '0));

    // R3: no pulse and no clear leaves the register alone.
    assert_pend_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_i == '0 && clr_i == '0) |=> $stable(pend_o));

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int           W    = irq_split_pkg::REG_W,
    parameter logic [W-1:0] IMPL = irq_split_pkg::IMPL_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);

    typedef struct packed {
        logic [W-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) st_d.mask = wdata_i & IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;

    // R5: mask changes only on a mask write.
    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(mask_o));

    // R6: unimplemented mask bits never become set.
    assert_mask_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> ((mask_o & ~IMPL) == '0));

endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge #(
    parameter int                 W      = irq_split_pkg::REG_W,
    parameter int                 N      = irq_split_pkg::N_LINES,
    parameter logic [N*W-1:0]     GROUPS = irq_split_pkg::LINE_GROUPS
) (
    input  logic [W-1:0] pend_i,
    input  logic [W-1:0] mask_i,
    output logic [N-1:0] line_o
);

    logic [W-1:0] live_d;
    assign live_d = pend_i & mask_i;

    for (genvar l = 0; l < N; l++) begin : g_line
        assign line_o[l] = |(live_d & GROUPS[l*W +: W]);
    end

endmodule

// File: rtl/irq_split_ctrl.sv
module irq_split_ctrl #(
    parameter int W = irq_split_pkg::REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         rd_sel,
    output logic [W-1:0] rd_data,
    input  logic [W-1:0] evt_pulse,
    output logic         irq_main,
    output logic         irq_timer
);
    import irq_split_pkg::*;

    localparam int N = N_LINES;

    logic [W-1:0] clr_d;
    logic         mask_we_d;
    logic [W-1:0] pend_q;
    logic [W-1:0] mask_q;
    logic [N-1:0] lines_d;

    always_comb begin
        clr_d     = '0;
        mask_we_d = 1'b0;
        if (wr_en) begin
            if (reg_sel_e'(wr_sel) == SEL_PEND) clr_d     = wr_data;
            else                                mask_we_d = 1'b1;
        end
    end

    irq_pend_bank #(.W(W), .IMPL(IMPL_BITS)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (evt_pulse),
        .clr_i   (clr_d),
        .pend_o  (pend_q)
    );

    irq_mask_bank #(.W(W), .IMPL(IMPL_BITS)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mask_we_d),
        .wdata_i (wr_data),
        .mask_o  (mask_q)
    );

    irq_line_merge #(.W(W), .N(N), .GROUPS(LINE_GROUPS)) u_merge (
        .pend_i  (pend_q),
        .mask_i  (mask_q),
        .line_o  (lines_d)
    );

    assign rd_data   = (reg_sel_e'(rd_sel) == SEL_MASK) ? mask_q : pend_q;
    assign irq_main  = lines_d[0];
    assign irq_timer = lines_d[1];

    // R1: both lines low on the first cycle out of reset.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq_main && !irq_timer));

    // R9: a mask write of all zeros silences both lines at the next edge.
    assert_mask_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && wr_data == '0) |=> (!irq_main && !irq_timer));

    // R8: the timer bit alone never lifts the main line.
    assert_main_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & mask_q & MAIN_GRP) == '0) |-> !irq_main);

    // R6: low read bits are zero.
    assert_read_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[TMR_BIT-1:0] == '0);

endmodule

// File: tb/irq_split_ctrl_test.sv
module irq_split_ctrl_test;

    localparam logic [31:0] IMPL = 32'hFFFF_8000;
    localparam logic [31:0] MAIN = 32'hFFFF_0000;

    typedef struct {
        logic        rsel;
        logic [31:0] rd;
        logic        main;
        logic        tmr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] evt_pulse = '0;
    logic        irq_main;
    logic        irq_timer;

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] pend_m = '0;
    logic [31:0] mask_m = '0;
    exp_t sb[$];
    bit done = 1'b0;

    irq_split_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .evt_pulse(evt_pulse), .irq_main(irq_main), .irq_timer(irq_timer)
    );

    always #5 clk = ~clk;

    // One operation: drive at negedge, model the edge, queue the expectation.
    task automatic step(input logic we, input logic sel, input logic [31:0] d,
                        input logic [31:0] p, input logic rs, input string tag);
        exp_t e;
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = d; evt_pulse = p;
        @(posedge clk);
        if (we && !sel) pend_m = pend_m & ~d;
        pend_m = (pend_m | p) & IMPL;
        if (we && sel) mask_m = d & IMPL;
        #1;
        wr_en = 1'b0; wr_data = '0; evt_pulse = '0; rd_sel = rs;
        e.rsel = rs;
        e.rd   = rs ? mask_m : pend_m;
        e.main = |(pend_m & mask_m & MAIN);
        e.tmr  = pend_m[15] & mask_m[15];
        e.tag  = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare queued expectations away from the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                vectors++;
                if (rd_data !== e.rd || irq_main !== e.main || irq_timer !== e.tmr) begin
                    miscompares++;
                    $display("FAIL %s: rd=%h main=%b tmr=%b expected rd=%h main=%b tmr=%b",
                             e.tag, rd_data, irq_main, irq_timer, e.rd, e.main, e.tmr);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step(0, 0, 0, 0, 0, "R1 reset pending");
        step(0, 0, 0, 0, 1, "R1 reset mask");
        step(0, 0, 0, 32'h0010_0000, 0, "R2 pulse bit20 unmasked-off");
        step(1, 1, 32'h0010_0000, 0, 1, "R5 R8 mask bit20");
        step(0, 0, 0, 32'h0000_8000, 0, "R2 R7 timer pending, masked off");
        step(1, 1, 32'h0010_8000, 0, 0, "R7 timer enabled, R5 pend unchanged");
        step(1, 0, 32'h0010_0000, 0, 0, "R3 R9 clear bit20");
        step(1, 0, 32'h0000_0000, 0, 0, "R3 zero write keeps");
        step(0, 0, 0, 32'h8000_0000, 0, "R2 pulse bit31");
        step(1, 0, 32'h8000_8000, 32'h8000_0000, 0, "R4 pulse beats clear");
        step(1, 1, 32'hFFFF_FFFF, 0, 1, "R6 mask low bits dropped");
        step(0, 0, 0, 32'h0000_7FFF, 0, "R6 low pulses ignored");
        step(1, 0, 32'h0000_7FFF, 0, 0, "R6 low clear no effect");
        step(1, 0, 32'hFFFF_FFFF, 0, 0, "R3 clear all");
        for (int b = 16; b < 32; b++) begin
            step(1, 1, 32'(1) << b, 0, 1, "R5 walk mask");
            step(0, 0, 0, 32'(1) << b, 0, "R8 walk pulse");
            step(0, 0, 0, 32'h0000_8000, 0, "R8 timer bit no effect on main");
            step(1, 0, 32'hFFFF_FFFF, 0, 0, "R9 walk clear");
        end
        step(1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R2 all pulses");
        step(1, 1, 32'h0000_8000, 0, 1, "R8 R9 main off timer on");
        step(1, 1, 32'h0000_0000, 0, 0, "R9 both off");
        step(1, 1, 32'h0001_0000, 0, 0, "R8 bit16 enabled");
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run hung, expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule